// File: doc/BRIEF.md
# Indirect Word Access and Conditional Transfer Sequencer

This block runs the execute phase of five extra opcodes of an 8-bit CPU after the opcode byte itself has been fetched and decoded. It moves a 16-bit word between HL and memory, using DE as the pointer. It takes or skips a jump on the state of the X5 condition bit, and fetches the jump target from the instruction stream when needed. It also performs a restart to a fixed vector when the overflow bit is set. All memory traffic goes over a byte-wide bus with separate read and write strobes.

The core pulses `start` with the opcode, the register pairs, the flag byte and a PC that already points past the opcode. The block then owns the bus until `done`. At `done` it presents the resulting HL, PC and SP. It also reports how many machine cycles the instruction costs, so the core can charge its timing. The results stay on the outputs until the next accepted `start`.

Top module: `xfer_seq`

## Requirements
- R1: Opcode 0xD9 writes HL[7:0] to address DE and then HL[15:8] to address DE+1 in the next clock. It reports 3 machine cycles, and `done` comes 3 clocks after the `start` edge.
- R2: Opcode 0xED reads address DE into HL[7:0] and address DE+1 into HL[15:8]. It reports 3 machine cycles, and `done` comes 5 clocks after the `start` edge.
- R3: The address DE+1 wraps modulo 65536, so DE=0xFFFF is followed by 0x0000.
- R4: Opcode 0xCB with flag bit 1 (overflow) set writes PC[15:8] to SP-1 and then PC[7:0] to SP-2. The result is SP-2 and PC=0x0040. It reports 3 machine cycles, and `done` comes 3 clocks after `start`.
- R5: Opcode 0xCB with flag bit 1 clear makes no bus access and returns HL, PC and SP unchanged. It reports 1 machine cycle, and `done` comes 1 clock after `start`.
- R6: Opcode 0xDD jumps when flag bit 5 (X5) is clear, and opcode 0xFD jumps when it is set. A taken jump reads the byte at PC and then the byte at PC+1, and sets PC to {second byte, first byte}. It reports 3 machine cycles, and `done` comes 5 clocks after `start`.
- R7: A jump that is not taken reads only the byte at PC and returns PC+2. It reports 2 machine cycles, and `done` comes 3 clocks after `start`.
- R8: A read returns its data in the clock after the read strobe. The address stays unchanged through that clock, and read and write strobes are never both high.
- R9: `done` is high for exactly one clock per accepted instruction.
- R10: Any other opcode makes no bus access and returns the inputs unchanged. It reports 0 machine cycles, and `done` comes 1 clock after `start`.
- R11: A `start` while `busy` is high is ignored. The running instruction completes with its own results and bus traffic.
- R12: Each instruction leaves unchanged the register pairs it does not target: HL for store, restart and jumps; SP for everything except a taken restart; PC for store and load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| opcode | input | 8 | Decoded opcode byte |
| de_in | input | 16 | DE register pair |
| hl_in | input | 16 | HL register pair |
| pc_in | input | 16 | PC, pointing past the opcode |
| sp_in | input | 16 | Stack pointer |
| flags_in | input | 8 | Condition byte; bit 5 is X5, bit 1 is overflow |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the clock after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| hl_out | output | 16 | Resulting HL |
| pc_out | output | 16 | Resulting PC |
| sp_out | output | 16 | Resulting SP |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-clock completion pulse |
| done_mcycles | output | 2 | Machine-cycle count, valid with `done` |

## Verification
Counted in clocks from the `start` edge, `done` comes 1 clock later for the untaken restart and for unknown opcodes. It comes 3 clocks later for the store, the taken restart and the untaken jump, and 5 clocks later for the load and the taken jump. The bench counts falling edges from the `start` edge until it sees `done` and compares that count with the expected value for the opcode. It reads `hl_out`, `pc_out`, `sp_out` and `done_mcycles` at the same falling edge, and checks one falling edge later that `done` has dropped. Bus traffic is logged at every falling edge. The memory model answers a read at the following rising edge with a byte computed from the address, and drives a garbage byte otherwise, so a capture taken one clock early or late shows up as a wrong HL or PC.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MC_W   = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [2:0] {
    K_NONE, K_STORE, K_LOAD, K_RST, K_JMP
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_LO, S_WR_HI, S_RD_LO, S_CAP_LO, S_RD_HI, S_CAP_HI, S_FIN
  } st_e;

  function automatic addr_t addr_inc(addr_t a, addr_t n);
    return a + n;
  endfunction

  function automatic addr_t addr_dec(addr_t a, addr_t n);
    return a - n;
  endfunction

  function automatic logic [MC_W-1:0] mc_of(kind_e k, logic taken);
    case (k)
      K_STORE, K_LOAD: return MC_W'(3);
      K_RST:           return taken ? MC_W'(3) : MC_W'(1);
      K_JMP:           return taken ? MC_W'(3) : MC_W'(2);
      default:         return MC_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/xseq_decode.sv
module xseq_decode
  import xseq_pkg::*;
#(
  parameter byte_t OP_STORE = 8'hD9,
  parameter byte_t OP_LOAD  = 8'hED,
  parameter byte_t OP_RST   = 8'hCB,
  parameter byte_t OP_JNX   = 8'hDD,
  parameter byte_t OP_JX    = 8'hFD,
  parameter int    V_BIT    = 1,
  parameter int    X5_BIT   = 5
) (
  input  byte_t           opcode,
  input  byte_t           flags,
  output kind_e           kind,
  output logic            taken,
  output logic [MC_W-1:0] mcycles
);
  logic  flag_v, flag_x5;
  byte_t unused_flags;

  assign flag_v       = flags[V_BIT];
  assign flag_x5      = flags[X5_BIT];
  assign unused_flags = flags;

  always_comb begin
    kind  = K_NONE;
    taken = 1'b0;
    if (opcode == OP_STORE) begin
      kind  = K_STORE;
      taken = 1'b1;
    end else if (opcode == OP_LOAD) begin
      kind  = K_LOAD;
      taken = 1'b1;
    end else if (opcode == OP_RST) begin
      kind  = K_RST;
      taken = flag_v;
    end else if (opcode == OP_JX) begin
      kind  = K_JMP;
      taken = flag_x5;
    end else if (opcode == OP_JNX) begin
      kind  = K_JMP;
      taken = !flag_x5;
    end
  end

  assign mcycles = mc_of(kind, taken);
endmodule

// File: rtl/xseq_ctrl.sv
module xseq_ctrl
  import xseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  kind_e           kind,
  input  logic            taken,
  input  logic [MC_W-1:0] mcycles,
  output st_e             state,
  output kind_e           kind_q,
  output logic            taken_q,
  output logic [MC_W-1:0] mc_q,
  output logic            accept,
  output logic            skip_mem,
  output logic            busy,
  output logic            done
);
  st_e nxt;

  assign accept = (state == S_IDLE) && start;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start) begin
        case (kind)
          K_STORE:      nxt = S_WR_LO;
          K_RST:        nxt = taken ? S_WR_LO : S_FIN;
          K_LOAD, K_JMP: nxt = S_RD_LO;
          default:      nxt = S_FIN;
        endcase
      end
      S_WR_LO:  nxt = S_WR_HI;
      S_WR_HI:  nxt = S_FIN;
      S_RD_LO:  nxt = S_CAP_LO;
      S_CAP_LO: nxt = (kind_q == K_JMP && !taken_q) ? S_FIN : S_RD_HI;
      S_RD_HI:  nxt = S_CAP_HI;
      S_CAP_HI: nxt = S_FIN;
      default:  nxt = S_IDLE;
    endcase
  end

  assign skip_mem = accept && (nxt == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind_q  <= K_NONE;
      taken_q <= 1'b0;
      mc_q    <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        kind_q  <= kind;
        taken_q <= taken;
        mc_q    <= mcycles;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/xseq_path.sv
module xseq_path
  import xseq_pkg::*;
#(
  parameter addr_t RST_VEC = 16'h0040
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  st_e   state,
  input  kind_e kind_q,
  input  logic  taken_q,
  input  addr_t de_in,
  input  addr_t hl_in,
  input  addr_t pc_in,
  input  addr_t sp_in,
  input  byte_t mem_rdata,
  output addr_t mem_addr,
  output byte_t mem_wdata,
  output logic  mem_rd,
  output logic  mem_wr,
  output addr_t hl_out,
  output addr_t pc_out,
  output addr_t sp_out
);
  localparam int LO_TOP = DATA_W - 1;
  localparam int HI_BOT = DATA_W;
  localparam int HI_TOP = ADDR_W - 1;

  addr_t de_q, pc_q, sp_q;
  addr_t hl_r, pc_r, sp_r;
  byte_t lo_q;
  addr_t rd_base;
  logic  is_load, is_rst;

  assign is_load = (kind_q == K_LOAD);
  assign is_rst  = (kind_q == K_RST);
  assign rd_base = is_load ? de_q : pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q <= '0; pc_q <= '0; sp_q <= '0;
      hl_r <= '0; pc_r <= '0; sp_r <= '0;
      lo_q <= '0;
    end else if (accept) begin
      de_q <= de_in; pc_q <= pc_in; sp_q <= sp_in;
      hl_r <= hl_in; pc_r <= pc_in; sp_r <= sp_in;
      lo_q <= '0;
    end else begin
      case (state)
        S_CAP_LO: begin
          if (is_load) hl_r[LO_TOP:0] <= mem_rdata;
          else begin
            lo_q <= mem_rdata;
            if (!taken_q) pc_r <= addr_inc(pc_q, addr_t'(2));
          end
        end
        S_CAP_HI: begin
          if (is_load) hl_r[HI_TOP:HI_BOT] <= mem_rdata;
          else         pc_r <= {mem_rdata, lo_q};
        end
        S_WR_HI: begin
          if (is_rst) begin
            sp_r <= addr_dec(sp_q, addr_t'(2));
            pc_r <= RST_VEC;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_WR_LO: begin
        if (is_rst) begin
          mem_addr  = addr_dec(sp_q, addr_t'(1));
          mem_wdata = pc_q[HI_TOP:HI_BOT];
        end else begin
          mem_addr  = de_q;
          mem_wdata = hl_r[LO_TOP:0];
        end
      end
      S_WR_HI: begin
        if (is_rst) begin
          mem_addr  = addr_dec(sp_q, addr_t'(2));
          mem_wdata = pc_q[LO_TOP:0];
        end else begin
          mem_addr  = addr_inc(de_q, addr_t'(1));
          mem_wdata = hl_r[HI_TOP:HI_BOT];
        end
      end
      S_RD_LO, S_CAP_LO: mem_addr = rd_base;
      S_RD_HI, S_CAP_HI: mem_addr = addr_inc(rd_base, addr_t'(1));
      default: ;
    endcase
  end

  assign mem_rd = (state == S_RD_LO) || (state == S_RD_HI);
  assign mem_wr = (state == S_WR_LO) || (state == S_WR_HI);
  assign hl_out = hl_r;
  assign pc_out = pc_r;
  assign sp_out = sp_r;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xseq_pkg::*;
#(
  parameter logic [7:0]  OP_STORE = 8'hD9,
  parameter logic [7:0]  OP_LOAD  = 8'hED,
  parameter logic [7:0]  OP_RST   = 8'hCB,
  parameter logic [7:0]  OP_JNX   = 8'hDD,
  parameter logic [7:0]  OP_JX    = 8'hFD,
  parameter int          V_BIT    = 1,
  parameter int          X5_BIT   = 5,
  parameter logic [15:0] RST_VEC  = 16'h0040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] de_in,
  input  logic [15:0] hl_in,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic [7:0]  flags_in,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] hl_out,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic        busy,
  output logic        done,
  output logic [1:0]  done_mcycles
);
  kind_e           dec_kind, kind_q;
  logic            dec_taken, taken_q;
  logic [MC_W-1:0] dec_mc, mc_q;
  st_e             state;
  logic            accept, skip_mem;

  // named events for the checker
  logic wr_lo_ev, is_store_q, is_rst_q;
  assign wr_lo_ev   = (state == S_WR_LO);
  assign is_store_q = (kind_q == K_STORE);
  assign is_rst_q   = (kind_q == K_RST);

  xseq_decode #(
    .OP_STORE(OP_STORE), .OP_LOAD(OP_LOAD), .OP_RST(OP_RST),
    .OP_JNX(OP_JNX), .OP_JX(OP_JX), .V_BIT(V_BIT), .X5_BIT(X5_BIT)
  ) u_dec (
    .opcode (opcode),
    .flags  (flags_in),
    .kind   (dec_kind),
    .taken  (dec_taken),
    .mcycles(dec_mc)
  );

  xseq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .kind    (dec_kind),
    .taken   (dec_taken),
    .mcycles (dec_mc),
    .state   (state),
    .kind_q  (kind_q),
    .taken_q (taken_q),
    .mc_q    (mc_q),
    .accept  (accept),
    .skip_mem(skip_mem),
    .busy    (busy),
    .done    (done)
  );

  xseq_path #(.RST_VEC(RST_VEC)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .state    (state),
    .kind_q   (kind_q),
    .taken_q  (taken_q),
    .de_in    (de_in),
    .hl_in    (hl_in),
    .pc_in    (pc_in),
    .sp_in    (sp_in),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .hl_out   (hl_out),
    .pc_out   (pc_out),
    .sp_out   (sp_out)
  );

  assign done_mcycles = done ? mc_q : '0;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [15:0] mem_addr,
  input logic        accept,
  input logic        skip_mem,
  input logic        wr_lo_ev,
  input logic        is_store_q,
  input logic        is_rst_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!mem_rd && mem_addr == $past(mem_addr))); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R8

  AST_STORE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_ev && is_store_q) |=> (mem_wr && mem_addr == $past(mem_addr) + 16'd1)); // R3

  AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_ev && is_rst_q) |=> (mem_wr && mem_addr == $past(mem_addr) - 16'd1)); // R4

  AST_NO_ACCESS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    skip_mem |=> (done && !mem_rd && !mem_wr)); // R10

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> !accept); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R5
endmodule

bind xfer_seq xfer_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .accept    (accept),
  .skip_mem  (skip_mem),
  .wr_lo_ev  (wr_lo_ev),
  .is_store_q(is_store_q),
  .is_rst_q  (is_rst_q)
);

// File: tb/tb_xfer_seq.sv
module tb_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] de_in = '0, hl_in = '0, pc_in = '0, sp_in = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] hl_out, pc_out, sp_out;
  logic        busy, done;
  logic [1:0]  done_mcycles;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          wn, rn;
  logic [15:0] wa [4];
  logic [7:0]  wd [4];
  logic [15:0] ra [4];

  always #2 clk = ~clk;

  xfer_seq dut (.*);

  function automatic logic [7:0] memfn(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // memory model: data due the clock after the read strobe
  always @(posedge clk) mem_rdata <= mem_rd ? memfn(mem_addr) : 8'hEE;

  always @(negedge clk) begin
    if (mem_wr && wn < 4) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; wn++; end
    if (mem_rd && rn < 4) begin ra[rn] = mem_addr; rn++; end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [7:0] op, logic [15:0] de, logic [15:0] hl,
                        logic [15:0] pc, logic [15:0] sp, logic [7:0] fl, bit poke);
    int lat;
    int e_lat, e_wn, e_rn;
    logic [1:0]  e_mc;
    logic [15:0] e_hl, e_pc, e_sp;
    logic [15:0] e_wa [2];
    logic [7:0]  e_wd [2];
    logic [15:0] e_ra [2];
    bit jt;
    e_hl = hl; e_pc = pc; e_sp = sp; e_wn = 0; e_rn = 0; e_mc = 0; e_lat = 1;
    e_wa[0] = 0; e_wa[1] = 0; e_wd[0] = 0; e_wd[1] = 0; e_ra[0] = 0; e_ra[1] = 0;
    jt = (op == 8'hFD) ? fl[5] : !fl[5];
    case (op)
      8'hD9: begin // R1 R3 R12
        e_wn = 2; e_wa[0] = de; e_wd[0] = hl[7:0];
        e_wa[1] = de + 16'd1; e_wd[1] = hl[15:8]; e_mc = 3; e_lat = 3;
      end
      8'hED: begin // R2 R3
        e_rn = 2; e_ra[0] = de; e_ra[1] = de + 16'd1;
        e_hl = {memfn(de + 16'd1), memfn(de)}; e_mc = 3; e_lat = 5;
      end
      8'hCB: if (fl[1]) begin // R4
        e_wn = 2; e_wa[0] = sp - 16'd1; e_wd[0] = pc[15:8];
        e_wa[1] = sp - 16'd2; e_wd[1] = pc[7:0];
        e_sp = sp - 16'd2; e_pc = 16'h0040; e_mc = 3; e_lat = 3;
      end else begin // R5
        e_mc = 1; e_lat = 1;
      end
      8'hDD, 8'hFD: if (jt) begin // R6
        e_rn = 2; e_ra[0] = pc; e_ra[1] = pc + 16'd1;
        e_pc = {memfn(pc + 16'd1), memfn(pc)}; e_mc = 3; e_lat = 5;
      end else begin // R7
        e_rn = 1; e_ra[0] = pc; e_pc = pc + 16'd2; e_mc = 2; e_lat = 3;
      end
      default: begin // R10
        e_mc = 0; e_lat = 1;
      end
    endcase

    @(negedge clk);
    opcode = op; de_in = de; hl_in = hl; pc_in = pc; sp_in = sp; flags_in = fl;
    start = 1'b1; wn = 0; rn = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (poke && lat == 1) begin // R11: intruding start while busy
        start = 1'b1; opcode = 8'hD9; hl_in = ~hl; de_in = ~de;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(lat == e_lat, "R9 done latency", lat, e_lat);
    chk(done_mcycles == e_mc, "R1/R2/R4/R5/R6/R7/R10 mcycles", done_mcycles, e_mc);
    chk(hl_out == e_hl, "R2/R12 hl_out", hl_out, e_hl);
    chk(pc_out == e_pc, "R4/R6/R7/R12 pc_out", pc_out, e_pc);
    chk(sp_out == e_sp, "R4/R12 sp_out", sp_out, e_sp);
    chk(wn == e_wn, "R1/R4/R11 write count", wn, e_wn);
    chk(rn == e_rn, "R2/R6/R7 read count", rn, e_rn);
    for (int i = 0; i < 2; i++) begin
      if (i < e_wn && i < wn) begin
        chk(wa[i] == e_wa[i], "R1/R3/R4 write addr", wa[i], e_wa[i]);
        chk(wd[i] == e_wd[i], "R1/R4 write data", wd[i], e_wd[i]);
      end
      if (i < e_rn && i < rn)
        chk(ra[i] == e_ra[i], "R2/R3/R6 read addr", ra[i], e_ra[i]);
    end
    @(negedge clk);
    chk(!done, "R9 done single clock", done, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [6];
    void'($urandom(32'd1234));
    ops[0] = 8'hD9; ops[1] = 8'hED; ops[2] = 8'hCB;
    ops[3] = 8'hDD; ops[4] = 8'hFD; ops[5] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_rd && !mem_wr, "R9 reset state",
        {done, busy, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_op(8'hD9, 16'hFFFF, 16'hA55A, 16'h1000, 16'h8000, 8'h00, 0); // R1 R3
    run_op(8'hED, 16'hFFFF, 16'h0000, 16'h1000, 16'h8000, 8'h00, 0); // R2 R3
    run_op(8'hCB, 16'h1234, 16'h5678, 16'hBEEF, 16'h0001, 8'h02, 0); // R4 wrap
    run_op(8'hCB, 16'h1234, 16'h5678, 16'hBEEF, 16'h4000, 8'hFD, 0); // R5
    run_op(8'hDD, 16'h0, 16'h1, 16'hFFFF, 16'h2, 8'h00, 0);          // R6 wrap
    run_op(8'hDD, 16'h0, 16'h1, 16'hFFFF, 16'h2, 8'h20, 0);          // R7
    run_op(8'hFD, 16'h0, 16'h1, 16'h2345, 16'h2, 8'h20, 0);          // R6
    run_op(8'hFD, 16'h0, 16'h1, 16'hFFFE, 16'h2, 8'hDF, 0);          // R7
    run_op(8'h76, 16'h9, 16'h8, 16'h7, 16'h6, 8'hFF, 0);             // R10
    run_op(8'hED, 16'h3000, 16'h1111, 16'h2, 16'h3, 8'h00, 1);       // R11
    run_op(8'hDD, 16'h3000, 16'h1111, 16'h4400, 16'h3, 8'h00, 1);    // R11

    // constrained random
    for (int n = 0; n < 200; n++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 5)];
      if (op == 8'h00) op = 8'($urandom);
      run_op(op, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             8'($urandom), ($urandom_range(0, 7) == 0));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule